// File: doc/BRIEF.md
# Sticky Right Shifter, 128 Bits

This block shifts a 128-bit value right by an unsigned amount. Any bit that falls off the bottom is not thrown away. Instead, all of the lost bits are OR-reduced and merged into bit 0 of the result, so a rounding stage further down still knows that the value was inexact. The value enters and leaves as two 64-bit halves.

The shift amount is eight bits wide. Any amount of 128 or more moves the whole value out. The result then collapses to a single flag in bit 0, which is set when the input had any bit set.

The path is purely combinational. Its typical use is to line up two significands before a wide addition in floating-point datapaths, where the guard and sticky information has to survive the alignment.

Top module: `sticky_rshift`

## Requirements
- R1: A shift amount of 0 returns both halves unchanged, and bit 0 gets no sticky merge.
- R2: For amounts 1 to 63, result bits 127..1 equal the 128-bit value shifted right logically. Bits of the high half cross into the top of the low half.
- R3: For amounts 1 to 127, result bit 0 is the plain shifted bit 0 ORed with the OR of every bit shifted out. When all lost bits are zero, bit 0 is the plain shifted bit.
- R4: An amount of exactly 64 gives a high half of zero. The low half is the old high half, with the OR of the whole old low half merged into its bit 0.
- R5: For amounts 65 to 127, the high half is zero. The low half is the old high half shifted right by (amount - 64), and the sticky bit covers the entire old low half as well as the high-half bits shifted out.
- R6: For amounts 128 to 255, the high half is zero and the low half is 1 if any input bit was set, otherwise 0. Every amount in that range gives the same result.
- R7: The outputs follow a change of the inputs with no clock edge in between.
- R8: An all-zero input gives an all-zero output for every amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_hi | input | 64 | Upper half of the value to shift |
| src_lo | input | 64 | Lower half of the value to shift |
| shamt | input | 8 | Unsigned right-shift amount |
| res_hi | output | 64 | Upper half of the shifted result |
| res_lo | output | 64 | Lower half of the shifted result, with bit 0 carrying the sticky flag |

## Verification
The bench drives every amount from 0 to 255 against several data patterns. The expected result comes from a 384-bit shift whose lower part is OR-reduced.

Patterns with only one low bit set go after the sticky logic:
- A design that drops lost bits leaves bit 0 clear where it must be set.
- A design that ORs in too wide a window sets bit 0 at amount 0, or at an amount that loses nothing.

Amounts 64, 127, 128 and 255 target the half-crossing and overflow paths:
- A design that decodes only the low seven amount bits wraps large amounts around into ordinary shifts.
- A design that mishandles the half boundary leaves stale data in the high half.

// File: rtl/sticky_rshift.sv
module sticky_rshift #(
  parameter int HALF = 64,
  parameter int CW   = 8
) (
  input  logic [HALF-1:0] src_hi,
  input  logic [HALF-1:0] src_lo,
  input  logic [CW-1:0]   shamt,
  output logic [HALF-1:0] res_hi,
  output logic [HALF-1:0] res_lo
);
  localparam int W  = 2 * HALF;
  localparam int LW = $clog2(W);

  logic [W-1:0] stg [0:LW];
  logic [LW:0]  stk;
  logic         ovf;
  logic [W-1:0] src, res;

  assign src    = {src_hi, src_lo};
  assign stg[0] = src;
  assign stk[0] = 1'b0;

  for (genvar k = 0; k < LW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = shamt[k] ? (stg[k] >> S) : stg[k];
    assign stk[k+1] = stk[k] | (shamt[k] & (|stg[k][S-1:0]));
  end

  if (CW > LW) begin : g_ovf
    assign ovf = |shamt[CW-1:LW];
  end else begin : g_no_ovf
    assign ovf = 1'b0;
  end

  assign res = ovf ? {{(W-1){1'b0}}, |src}
                   : {stg[LW][W-1:1], stg[LW][0] | stk[LW]};

  assign res_hi = res[W-1:HALF];
  assign res_lo = res[HALF-1:0];
endmodule

module sticky_rshift_chk #(
  parameter int HALF = 64,
  parameter int CW   = 8
) (
  input logic [HALF-1:0] src_hi,
  input logic [HALF-1:0] src_lo,
  input logic [CW-1:0]   shamt,
  input logic [HALF-1:0] res_hi,
  input logic [HALF-1:0] res_lo
);
  localparam int W = 2 * HALF;
  logic [W-1:0] vin, vout;
  assign vin  = {src_hi, src_lo};
  assign vout = {res_hi, res_lo};

  always_comb begin
    // R1
    zero_amount_chk: assert (shamt != '0 || vout == vin);
    // R6
    collapse_chk: assert (int'(shamt) < W || vout == {{(W-1){1'b0}}, |vin});
    // R4
    upper_clear_chk: assert (int'(shamt) < HALF || res_hi == '0);
    // R3
    sticky_keep_chk: assert (shamt == '0 || (|vout) == (|vin));
    // R8
    zero_in_chk: assert (vin != '0 || vout == '0);
    // R2
    body_shift_chk: assert (int'(shamt) >= W || vout[W-1:1] == (vin >> shamt) >> 1);
  end
endmodule

bind sticky_rshift sticky_rshift_chk #(.HALF(HALF), .CW(CW)) u_chk (
  .src_hi(src_hi), .src_lo(src_lo), .shamt(shamt), .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/sticky_rshift_test.sv
module sticky_rshift_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [63:0] src_hi, src_lo, res_hi, res_lo;
  logic [7:0]  shamt;
  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [127:0] exp_q [$];
  string        tag_q [$];

  sticky_rshift uut (.src_hi(src_hi), .src_lo(src_lo), .shamt(shamt),
                     .res_hi(res_hi), .res_lo(res_lo));

  function automatic logic [127:0] ref_shift(logic [127:0] v, logic [7:0] c);
    logic [383:0] wide;
    wide = {v, 256'b0} >> c;
    return wide[383:256] | {127'b0, |wide[255:0]};
  endfunction

  function automatic string tag_of(logic [127:0] v, logic [7:0] c);
    if (v == '0) return "R8";
    if (c == 0) return "R1";
    if (c < 64) return "R2";
    if (c == 64) return "R4";
    if (c < 128) return "R5";
    return "R6";
  endfunction

  task automatic drive(logic [127:0] v, logic [7:0] c, string tg);
    @(posedge clk);
    {src_hi, src_lo} = v;
    shamt = c;
    exp_q.push_back(ref_shift(v, c));
    tag_q.push_back(tg);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [127:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if ({res_hi, res_lo} !== e) begin
        mismatched++;
        $display("FAIL %s: amount=%0d actual=%h expected=%h", t, shamt, {res_hi, res_lo}, e);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [127:0] pats [6];
    src_hi = '0; src_lo = '0; shamt = '0;
    pats[0] = {64'hDEAD_BEEF_0123_4567, 64'h89AB_CDEF_FEDC_BA98};
    pats[1] = 128'h1;
    pats[2] = {64'h8000_0000_0000_0000, 64'h0};
    pats[3] = {64'h0, 64'h8000_0000_0000_0001};
    pats[4] = {32{4'hA}};
    pats[5] = {$urandom, $urandom, $urandom, $urandom};
    // reset-state / R1 / R8
    drive('0, 8'd0, "R8");
    for (int p = 0; p < 6; p++)
      for (int c = 0; c < 256; c++)
        drive(pats[p], 8'(c), tag_of(pats[p], 8'(c)));
    // R3: only a single lost bit carries the sticky information
    for (int c = 1; c < 128; c++) begin
      drive(128'h1 << (c - 1), 8'(c), "R3");
      drive(128'h1 << c, 8'(c), "R3");
    end
    // R4 / R5 / R6 boundaries with random data
    for (int i = 0; i < 40; i++) begin
      logic [127:0] v;
      v = {$urandom, $urandom, $urandom, $urandom};
      drive(v, 8'd64, "R4");
      drive(v, 8'd127, "R5");
      drive(v, 8'd128, "R6");
      drive(v, 8'd255, "R6");
      drive('0, 8'($urandom), "R8");
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
    // R7: inputs change with no clock edge before the sample
    @(posedge clk);
    #1;
    {src_hi, src_lo} = pats[0];
    shamt = 8'd4;
    #1;
    compared++;
    if ({res_hi, res_lo} !== ref_shift(pats[0], 8'd4)) begin
      mismatched++;
      $display("FAIL R7: actual=%h expected=%h", {res_hi, res_lo}, ref_shift(pats[0], 8'd4));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule